// File: doc/BRIEF.md
# Cartridge ROM Bank Selector

This block chooses which bank of a large flash or ROM device appears in the 16 KB ROM window of an 8-bit host's expansion bus. It carries no data. It watches the host's memory reads. A read that lands in a small control area at the very top of the ROM window is treated as a command, and the command is carried in the low address bits of that read. The resulting bank number drives the upper address lines of the external memory.

In the default serial variant the control area is four bytes, 0x3FFC to 0x3FFF. Each control read moves address bit 0 into the bank register. Address bit 1 freezes the register until reset. Software can therefore build a six-bit bank number with six reads and then lock it, while giving up only four bytes of the window. A parameter selects a parallel variant instead. In that variant one read in the last 64 ROM addresses loads five bank bits at once. An optional output releases the cartridge ROM select when bank 0 is locked, so the host's own ROM becomes visible again.

The block samples the bus on a fast system clock. A command takes effect on the clock edge at which the block first sees the combined memory-request-and-read condition low after it was high.

Top module: `cart_bank_sel`

## Requirements
- R1: After reset the bank output is 0, the lock flag is 0 and the ROM select output is 1.
- R2: In the serial variant only reads at 0x3FFC to 0x3FFF change state. Reads elsewhere in the ROM window (for example 0x0000 or 0x3FFB) leave the bank and lock unchanged.
- R3: Any access with A15 or A14 set is a RAM access and is ignored, even when its low 14 bits match the control area (for example 0x7FFF, 0xBFFD, 0xFFFF).
- R4: In the serial variant each control read moves its A0 into bank bit 0, moves every other bit up by one place and drops the old top bit.
- R5: A serial control read with A1 = 1 still moves its A0 in, and then sets the lock. While the lock is set, no control read changes the bank or the lock.
- R6: A command acts once per read strobe, on the edge at which mreq_i AND rd_i is first seen low after being high. Holding the strobe for many cycles acts only once. A write (mreq_i = 1, rd_i = 0) has no effect.
- R7: With release enabled, rom_sel_o is 0 exactly when the lock is set and the bank is 0. Otherwise rom_sel_o is 1.
- R8: In the parallel variant the control area is 0x3FC0 to 0x3FFF. A read there sets the bank to the zero-extended address bits 4..0, and address bit 5 = 1 sets the lock.
- R9: Driving rst_ni low clears the bank and the lock at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mreq_i | input | 1 | Host memory request, active high |
| rd_i | input | 1 | Host read strobe, active high |
| addr_i | input | 16 | Host address bus |
| bank_o | output | BANK_W | Bank number to the external memory's upper address lines |
| locked_o | output | 1 | Bank register frozen until reset |
| rom_sel_o | output | 1 | Cartridge ROM select enable |

## Verification
If the bank register takes the wrong bit, shifts in the wrong direction or shifts twice, bank_o shows a wrong value on the first edge after the strobe falls. It stays wrong until the following reads push the bad bit out of the top of the register. A lock that fails to hold, or that sets when it should not, shows as a change in bank_o on a later control read, or as a missing change. A fault in the bank-0 release shows at once on rom_sel_o. The sweeps compare every output after every bus access, so each fault is reported at the access that causes it.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

   typedef enum logic {
      LOAD_SERIAL   = 1'b0,
      LOAD_PARALLEL = 1'b1
   } load_mode_e;

   // Upper edge of the host ROM window (16 KB, A15 = A14 = 0)
   localparam int ROM_TOP_BIT = 13;
   localparam int ADDR_W      = 16;

   // Width of the control-area offset for a given variant
   function automatic int win_bits(input load_mode_e mode, input int par_data_w);
      return (mode == LOAD_PARALLEL) ? par_data_w + 1 : 2;
   endfunction

endpackage

// File: rtl/cbs_strobe_edge.sv
module cbs_strobe_edge
   import cart_bank_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mreq_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              fire_o,
   output logic [ADDR_W-1:0] addr_cap_o
);

   logic rd_cyc;
   logic rd_cyc_q;

   assign rd_cyc = mreq_i & rd_i;

   // Hold the address seen while the read cycle is active
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_cyc_q   <= 1'b0;
         addr_cap_o <= '0;
      end else begin
         rd_cyc_q <= rd_cyc;
         if (rd_cyc) addr_cap_o <= addr_i;
      end
   end

   // Single pulse when the read cycle ends
   assign fire_o = rd_cyc_q & ~rd_cyc;

endmodule

// File: rtl/cbs_window_dec.sv
module cbs_window_dec
   import cart_bank_pkg::*;
#(
   parameter int WIN_W = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              rom_area_o,
   output logic              hit_o
);

   logic top_ones;

   assign rom_area_o = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b00);
   assign top_ones   = &addr_i[ROM_TOP_BIT:WIN_W];
   assign hit_o      = rom_area_o & top_ones;

endmodule

// File: rtl/cbs_bank_reg.sv
module cbs_bank_reg
   import cart_bank_pkg::*;
#(
   parameter int         BANK_W            = 6,
   parameter load_mode_e MODE              = LOAD_SERIAL,
   parameter int         PAR_DATA_W        = 5,
   parameter bit         PAR_LOCK_ON_FIRST = 1'b0,
   localparam int        WIN_W             = win_bits(MODE, PAR_DATA_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [WIN_W-1:0]  ofs_i,
   output logic [BANK_W-1:0] bank_o,
   output logic              locked_o
);

   logic [BANK_W-1:0] bank_nx;
   logic              lock_nx;

   generate
      if (MODE == LOAD_SERIAL) begin : g_serial
         always_comb begin
            bank_nx = {bank_o[BANK_W-2:0], ofs_i[0]};
            lock_nx = ofs_i[1];
         end
      end else begin : g_parallel
         always_comb begin
            bank_nx = BANK_W'(ofs_i[PAR_DATA_W-1:0]);
            lock_nx = PAR_LOCK_ON_FIRST ? 1'b1 : ofs_i[PAR_DATA_W];
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bank_o   <= '0;
         locked_o <= 1'b0;
      end else if (load_i && !locked_o) begin
         bank_o   <= bank_nx;
         locked_o <= lock_nx;
      end
   end

endmodule

// File: rtl/cart_bank_sel.sv
module cart_bank_sel
   import cart_bank_pkg::*;
#(
   parameter int         BANK_W            = 6,
   parameter load_mode_e MODE              = LOAD_SERIAL,
   parameter int         PAR_DATA_W        = 5,
   parameter bit         PAR_LOCK_ON_FIRST = 1'b0,
   parameter bit         BANK0_RELEASE     = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mreq_i,
   input  logic              rd_i,
   input  logic [15:0]       addr_i,
   output logic [BANK_W-1:0] bank_o,
   output logic              locked_o,
   output logic              rom_sel_o
);

   localparam int WIN_W = win_bits(MODE, PAR_DATA_W);

   generate
      if (BANK_W < 2) begin : g_bad_bank
         $error("BANK_W must be at least 2");
      end
      if (MODE == LOAD_PARALLEL && (PAR_DATA_W < 1 || PAR_DATA_W > BANK_W)) begin : g_bad_par
         $error("PAR_DATA_W must lie in 1..BANK_W");
      end
      if (WIN_W > ROM_TOP_BIT) begin : g_bad_win
         $error("control area too large for ROM window");
      end
   endgenerate

   logic              fire;
   logic [ADDR_W-1:0] addr_cap;
   logic              rom_area;
   logic              hit;

   cbs_strobe_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mreq_i     (mreq_i),
      .rd_i       (rd_i),
      .addr_i     (addr_i),
      .fire_o     (fire),
      .addr_cap_o (addr_cap)
   );

   cbs_window_dec #(.WIN_W(WIN_W)) u_dec (
      .addr_i     (addr_cap),
      .rom_area_o (rom_area),
      .hit_o      (hit)
   );

   cbs_bank_reg #(
      .BANK_W            (BANK_W),
      .MODE              (MODE),
      .PAR_DATA_W        (PAR_DATA_W),
      .PAR_LOCK_ON_FIRST (PAR_LOCK_ON_FIRST)
   ) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (fire & hit),
      .ofs_i    (addr_cap[WIN_W-1:0]),
      .bank_o   (bank_o),
      .locked_o (locked_o)
   );

   generate
      if (BANK0_RELEASE) begin : g_release
         assign rom_sel_o = ~(locked_o & (bank_o == '0));
      end else begin : g_always
         assign rom_sel_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/cbs_chk.sv
module cbs_chk
   import cart_bank_pkg::*;
#(
   parameter int         BANK_W        = 6,
   parameter load_mode_e MODE          = LOAD_SERIAL,
   parameter int         PAR_DATA_W    = 5,
   parameter bit         BANK0_RELEASE = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              mreq_i,
   input logic              rd_i,
   input logic [15:0]       addr_i,
   input logic [BANK_W-1:0] bank_o,
   input logic              locked_o,
   input logic              rom_sel_o
);

   localparam int WIN_W = win_bits(MODE, PAR_DATA_W);

   logic        c_q;
   logic [15:0] a_q;
   logic        fire;
   logic        hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         c_q <= 1'b0;
         a_q <= '0;
      end else begin
         c_q <= mreq_i & rd_i;
         if (mreq_i & rd_i) a_q <= addr_i;
      end
   end

   assign fire = c_q & ~(mreq_i & rd_i);
   assign hit  = (a_q[15:14] == 2'b00) && (&a_q[13:WIN_W]);

   // R5
   lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |=> locked_o);

   // R5
   lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |=> $stable(bank_o));

   // R6
   no_strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire |=> ($stable(bank_o) && $stable(locked_o)));

   // R3
   ram_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && a_q[15:14] != 2'b00) |=> ($stable(bank_o) && $stable(locked_o)));

   generate
      if (MODE == LOAD_SERIAL) begin : g_ser
         // R4
         shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fire && hit && !locked_o) |=>
               (bank_o == {$past(bank_o[BANK_W-2:0]), $past(a_q[0])}));
      end else begin : g_par
         // R8
         par_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fire && hit && !locked_o) |=>
               (bank_o[PAR_DATA_W-1:0] == $past(a_q[PAR_DATA_W-1:0])));
      end
      if (BANK0_RELEASE) begin : g_rel
         // R7
         release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (locked_o && bank_o == '0) |-> !rom_sel_o);
         // R7
         keep_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !locked_o |-> rom_sel_o);
      end
   endgenerate

endmodule

bind cart_bank_sel cbs_chk #(
   .BANK_W        (BANK_W),
   .MODE          (MODE),
   .PAR_DATA_W    (PAR_DATA_W),
   .BANK0_RELEASE (BANK0_RELEASE)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .mreq_i    (mreq_i),
   .rd_i      (rd_i),
   .addr_i    (addr_i),
   .bank_o    (bank_o),
   .locked_o  (locked_o),
   .rom_sel_o (rom_sel_o)
);

// File: tb/sim_cart_bank_sel.sv
module sim_cart_bank_sel;
   import cart_bank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mreq = 1'b0;
   logic        rd = 1'b0;
   logic [15:0] addr = '0;

   logic [5:0]  s_bank, p_bank;
   logic        s_lock, p_lock, s_sel, p_sel;

   int          n_vec = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   // expected state
   logic [5:0]  es_bank, ep_bank;
   logic        es_lock, ep_lock;

   always #4 clk = ~clk;

   cart_bank_sel u0 (
      .clk_i(clk), .rst_ni(rst_n), .mreq_i(mreq), .rd_i(rd), .addr_i(addr),
      .bank_o(s_bank), .locked_o(s_lock), .rom_sel_o(s_sel));

   cart_bank_sel #(.MODE(LOAD_PARALLEL)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .mreq_i(mreq), .rd_i(rd), .addr_i(addr),
      .bank_o(p_bank), .locked_o(p_lock), .rom_sel_o(p_sel));

   task automatic model_reset();
      es_bank = '0; es_lock = 1'b0;
      ep_bank = '0; ep_lock = 1'b0;
   endtask

   // Requirement-level model of one completed bus cycle
   task automatic model_apply(input logic [15:0] a, input bit is_rd);
      if (is_rd && a[15:14] == 2'b00) begin
         if (!es_lock && a[15:2] == 14'h0FFF) begin
            es_bank = {es_bank[4:0], a[0]};
            es_lock = a[1];
         end
         if (!ep_lock && a[15:6] == 10'h0FF) begin
            ep_bank = {1'b0, a[4:0]};
            ep_lock = a[5];
         end
      end
   endtask

   task automatic cmp(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      cmp(req, "serial bank", s_bank, es_bank);
      cmp(req, "serial lock", s_lock, es_lock);
      cmp(req, "serial sel (R7)", s_sel, !(es_lock && es_bank == 0));
      cmp(req, "parallel bank", p_bank, ep_bank);
      cmp(req, "parallel lock", p_lock, ep_lock);
      cmp(req, "parallel sel (R7)", p_sel, !(ep_lock && ep_bank == 0));
   endtask

   task automatic bus(input logic [15:0] a, input bit is_rd, input int hold, input string req);
      @(negedge clk);
      addr = a; mreq = 1'b1; rd = is_rd;
      repeat (hold) @(negedge clk);
      mreq = 1'b0; rd = 1'b0;
      model_apply(a, is_rd);
      @(negedge clk);
      @(negedge clk);
      check_all(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R4: serial sweep of all bank values, MSB first, no lock
      for (int v = 0; v < 64; v++) begin
         for (int b = 5; b >= 0; b--)
            bus(16'h3FFC | 16'(v[b]), 1'b1, 1 + (b % 3), "R4");
         cmp("R4", "serial sweep value", s_bank, v);
      end

      // R2: ROM addresses outside the control area
      bus(16'h3FFB, 1'b1, 1, "R2");
      bus(16'h0000, 1'b1, 1, "R2");
      bus(16'h1FFF, 1'b1, 1, "R2");
      // R3: RAM mirrors of the control area
      bus(16'h7FFF, 1'b1, 1, "R3");
      bus(16'hBFFD, 1'b1, 1, "R3");
      bus(16'hFFFF, 1'b1, 1, "R3");
      bus(16'hFFFE, 1'b1, 1, "R3");
      // R6: write ignored, long strobe acts once
      bus(16'h3FFF, 1'b0, 2, "R6");
      bus(16'h3FFD, 1'b1, 20, "R6");

      // R5: lock on a non-zero bank, then attempts to change it
      do_reset();
      bus(16'h3FFD, 1'b1, 1, "R5");
      bus(16'h3FFC, 1'b1, 1, "R5");
      bus(16'h3FFF, 1'b1, 1, "R5");
      cmp("R5", "serial locked bank", s_bank, 5);
      for (int k = 0; k < 4; k++) bus(16'h3FFC | 16'(k), 1'b1, 1, "R5");
      cmp("R5", "lock sticky", s_lock, 1);

      // R9: asynchronous reset between edges
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1;
      model_reset();
      check_all("R9");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: serial lock on bank 0 releases the select
      for (int k = 0; k < 5; k++) bus(16'h3FFC, 1'b1, 1, "R7");
      bus(16'h3FFE, 1'b1, 1, "R7");
      cmp("R7", "serial sel released", s_sel, 0);

      // R8: parallel sweep of every 5-bit value without lock
      do_reset();
      for (int v = 0; v < 32; v++) begin
         bus(16'h3FC0 | 16'(v), 1'b1, 1 + (v % 2), "R8");
         cmp("R8", "parallel value", p_bank, v);
      end
      bus(16'h3FBF, 1'b1, 1, "R8");
      bus(16'h7FC3, 1'b1, 1, "R3");
      // R8 lock with value 19, then frozen
      bus(16'h3FF3, 1'b1, 1, "R8");
      cmp("R8", "parallel lock", p_lock, 1);
      bus(16'h3FC7, 1'b1, 1, "R8");
      cmp("R8", "parallel frozen", p_bank, 19);

      // R7: parallel lock on bank 0
      do_reset();
      bus(16'h3FE0, 1'b1, 1, "R7");
      cmp("R7", "parallel sel released", p_sel, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule